// File: doc/BRIEF.md
# Programmable Accumulator Timer/Counter

This block is a 32-bit timer/counter that software drives through a small memory-mapped register bus. On each active tick it adds a programmable step to its running total, not a fixed one. When the total reaches or crosses a programmed threshold, a timer output toggles and a sticky event flag is set. The tick comes from one of four sources: the system clock itself, or one of three slower clocks (crystal, external, RC oscillator). Each of the slower clocks is synchronized into the system clock domain and edge-detected.

A one-shot mode stops counting at the first event. Continuous mode either restarts from zero after each event or keeps accumulating and wraps modulo 2^32. One control bit routes the toggling output either to a GPIO pin or, through the sticky flag, to a level interrupt line.

The bus request channel is valid/ready. A request transfers on a clock edge where `bus_valid` and `bus_ready` are both high. A read returns its data on the response channel one cycle later. `rsp_valid` and `rsp_data` stay steady until `rsp_ready` is seen high. While a response is pending, `bus_ready` is low, so the requester is back-pressured until the response drains. Writes produce no response.

Top module: `acc_timer`

## Requirements
- R1: After reset, every register reads 0, and `tmr_gpio`, `tmr_irq` and `rsp_valid` are low.
- R2: Registers sit at byte addresses 0x00 control, 0x04 step, 0x08 threshold, 0x0C counter and 0x10 status. Addresses are word-aligned, meaning bits 1:0 must be zero. Control bits are: bit0 enable, bit1 one-shot, bit2 wrap (1 = wrap, 0 = restart at zero), bit3 route (1 = interrupt, 0 = GPIO), bits 5:4 source (0 system clock, 1 crystal, 2 external, 3 RC). Control, step and threshold read back what was written.
- R3: A request transfers when `bus_valid` and `bus_ready` are both high. Read data appears with `rsp_valid` on the next cycle and is held steady until `rsp_ready`. `bus_ready` stays low while a response is pending.
- R4: Source 0 gives a tick on every cycle. Any other source gives exactly one tick per rising edge of its own input, after a two-flop synchronizer. The inputs of sources that are not selected have no effect.
- R5: On each tick, while enabled and not halted, the counter adds the step value. While the block is disabled, the counter holds.
- R6: An event occurs on a step where either the counter was below the threshold and the new sum is at or above it, or the 33-bit sum carries out. Each event toggles the timer output and sets the sticky flag (status bit0).
- R7: In one-shot mode, an event halts the counter at the new sum. A write to the counter or control register re-arms it.
- R8: In continuous mode with wrap clear, the counter becomes 0 on an event.
- R9: In continuous mode with wrap set, the counter keeps the 32-bit sum on an event, wrapping modulo 2^32.
- R10: With route at 0, `tmr_gpio` carries the toggle output and `tmr_irq` is low. With route at 1, `tmr_irq` equals the sticky flag and `tmr_gpio` is low.
- R11: Writing 1 to status bit0 clears the sticky flag, unless an event occurs in the same cycle.
- R12: A write to the counter register loads that value. If a tick falls in the same cycle, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_xtal | input | 1 | Crystal clock tick source |
| src_ext | input | 1 | External clock tick source |
| src_rc | input | 1 | RC oscillator tick source |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response accepted |
| rsp_data | output | 32 | Read response data |
| tmr_gpio | output | 1 | Toggle output when routed to GPIO |
| tmr_irq | output | 1 | Level interrupt when routed to interrupt |

## Verification
Assertions in the RTL check several rules on every cycle:
- a pending response stays steady until it is taken;
- each synchronized source edge gives a single-cycle tick;
- the counter is frozen while disabled or halted;
- every event flips the toggle and sets the sticky flag;
- a restart-mode event leaves the counter at zero.

The bench's scenarios are the only place where the arithmetic results are shown. These are the final values after threshold crossings and carry-outs, rejection of unselected sources, re-arming after one-shot, the interrupt routing and the write-1-to-clear behaviour. All of them are read back through the bus.

// File: rtl/acc_timer_pkg.sv
package acc_timer_pkg;
  typedef enum logic [1:0] {
    SRC_SYS  = 2'd0,
    SRC_XTAL = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_RC   = 2'd3
  } src_e;

  // packed MSB first: src[5:4], route[3], wrap[2], one_shot[1], enable[0]
  typedef struct packed {
    src_e src;
    logic route_irq;
    logic wrap;
    logic one_shot;
    logic enable;
  } ctrl_t;

  localparam int unsigned CTRL_W  = $bits(ctrl_t);
  localparam int unsigned N_SLOW  = 3;
  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_STEP = 1;
  localparam int unsigned IDX_THR  = 2;
  localparam int unsigned IDX_CNT  = 3;
  localparam int unsigned IDX_STS  = 4;
endpackage

// File: rtl/acc_tick_sync.sv
module acc_tick_sync #(
  parameter int unsigned N_SRC  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_in,
  output logic [N_SRC-1:0] pulse
);
  localparam int unsigned SH_W = STAGES + 1;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic [SH_W-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SH_W-2:0], src_in[i]};
    end
    assign pulse[i] = sh[STAGES-1] & ~sh[STAGES];

    // R4: one tick per source edge
    a_r4_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[i] |=> !pulse[i]);
  end
endmodule

// File: rtl/acc_regs.sv
module acc_regs
  import acc_timer_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  output logic          bus_ready,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] step_o,
  output logic [DW-1:0] thr_o,
  output logic          cnt_wr_o,
  output logic          sts_clr_o,
  output logic          rearm_o,
  input  logic [DW-1:0] cnt_i,
  input  logic          sticky_i
);
  localparam int unsigned IW = AW - 2;

  logic          accept, aligned;
  logic [IW-1:0] idx;
  logic          s_ctrl, s_step, s_thr, s_cnt, s_sts;
  logic [DW-1:0] rd_mux;

  assign bus_ready = !rsp_valid;
  assign accept    = bus_valid && bus_ready;
  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign idx       = bus_addr[AW-1:2];

  always_comb begin
    s_ctrl = aligned && (idx == IW'(IDX_CTRL));
    s_step = aligned && (idx == IW'(IDX_STEP));
    s_thr  = aligned && (idx == IW'(IDX_THR));
    s_cnt  = aligned && (idx == IW'(IDX_CNT));
    s_sts  = aligned && (idx == IW'(IDX_STS));
    rd_mux = '0;
    if (s_ctrl)      rd_mux = {{(DW-CTRL_W){1'b0}}, ctrl_o};
    else if (s_step) rd_mux = step_o;
    else if (s_thr)  rd_mux = thr_o;
    else if (s_cnt)  rd_mux = cnt_i;
    else if (s_sts)  rd_mux = {{(DW-1){1'b0}}, sticky_i};
  end

  assign cnt_wr_o  = accept && bus_write && s_cnt;
  assign sts_clr_o = accept && bus_write && s_sts && bus_wdata[0];
  assign rearm_o   = accept && bus_write && (s_cnt || s_ctrl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o    <= '0;
      step_o    <= '0;
      thr_o     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (accept && bus_write) begin
        if (s_ctrl) ctrl_o <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        if (s_step) step_o <= bus_wdata;
        if (s_thr)  thr_o  <= bus_wdata;
      end
      if (accept && !bus_write) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_mux;
      end else if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R3: a pending response is held until taken
  a_r3_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_timer_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  ctrl_t         ctrl,
  input  logic [DW-1:0] step_val,
  input  logic [DW-1:0] thr,
  input  logic          cnt_wr,
  input  logic [DW-1:0] cnt_wdata,
  input  logic          sts_clr,
  input  logic          rearm,
  output logic [DW-1:0] cnt,
  output logic          toggle,
  output logic          sticky
);
  logic          halted, adv, evt;
  logic [DW:0]   sum;

  assign adv = ctrl.enable && tick && !halted && !cnt_wr;
  assign sum = {1'b0, cnt} + {1'b0, step_val};
  assign evt = adv && (sum[DW] || ((sum[DW-1:0] >= thr) && (cnt < thr)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      toggle <= 1'b0;
      sticky <= 1'b0;
      halted <= 1'b0;
    end else begin
      if (cnt_wr)
        cnt <= cnt_wdata;
      else if (adv)
        cnt <= (evt && !ctrl.one_shot && !ctrl.wrap) ? '0 : sum[DW-1:0];

      if (evt) toggle <= ~toggle;

      if (evt)          sticky <= 1'b1;
      else if (sts_clr) sticky <= 1'b0;

      if (rearm)                     halted <= 1'b0;
      else if (evt && ctrl.one_shot) halted <= 1'b1;
    end
  end

  // R5: disabled counter holds
  a_r5_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.enable && !cnt_wr |=> $stable(cnt));
  // R7: halted counter holds
  a_r7_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !cnt_wr |=> $stable(cnt));
  // R6: event flips toggle and sets sticky
  a_r6_evt_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (toggle != $past(toggle)) && sticky);
  // R8: restart mode returns to zero
  a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    evt && !ctrl.one_shot && !ctrl.wrap |=> cnt == '0);
endmodule

// File: rtl/acc_timer.sv
module acc_timer
  import acc_timer_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_xtal,
  input  logic              src_ext,
  input  logic              src_rc,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              tmr_gpio,
  output logic              tmr_irq
);
  ctrl_t              ctrl;
  logic [DATA_W-1:0]  step_val, thr, cnt;
  logic               cnt_wr, sts_clr, rearm, toggle, sticky, tick;
  logic [N_SLOW-1:0]  slow_pulse;

  acc_tick_sync #(.N_SRC(N_SLOW), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .src_in({src_rc, src_ext, src_xtal}),
    .pulse(slow_pulse)
  );

  always_comb begin
    case (ctrl.src)
      SRC_XTAL: tick = slow_pulse[0];
      SRC_EXT:  tick = slow_pulse[1];
      SRC_RC:   tick = slow_pulse[2];
      default:  tick = 1'b1;
    endcase
  end

  acc_regs #(.DW(DATA_W), .AW(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .ctrl_o(ctrl), .step_o(step_val), .thr_o(thr),
    .cnt_wr_o(cnt_wr), .sts_clr_o(sts_clr), .rearm_o(rearm),
    .cnt_i(cnt), .sticky_i(sticky)
  );

  acc_core #(.DW(DATA_W)) core_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl(ctrl),
    .step_val(step_val), .thr(thr),
    .cnt_wr(cnt_wr), .cnt_wdata(bus_wdata),
    .sts_clr(sts_clr), .rearm(rearm),
    .cnt(cnt), .toggle(toggle), .sticky(sticky)
  );

  assign tmr_gpio = toggle & ~ctrl.route_irq;
  assign tmr_irq  = sticky &  ctrl.route_irq;

  // R10: the two routed outputs are never high together
  a_r10_route_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(tmr_gpio && tmr_irq));
endmodule

// File: tb/acc_timer_tb_top.sv
module acc_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_xtal = 1'b0, src_ext = 1'b0, src_rc = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic        bus_ready, rsp_valid, tmr_gpio, tmr_irq;
  logic [31:0] rsp_data;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;  // 250 MHz

  acc_timer dut_i (
    .clk(clk), .rst_n(rst_n),
    .src_xtal(src_xtal), .src_ext(src_ext), .src_rc(src_rc),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .tmr_gpio(tmr_gpio), .tmr_irq(tmr_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    while (!bus_ready) @(negedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    issue(1'b1, a, d);
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    issue(1'b0, a, 32'h0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R3 unexpected response act=%h exp=none", rsp_data);
      end else begin
        chk(tag_q.pop_front(), rsp_data, exp_q.pop_front());
      end
    end
  end

  task automatic pulses(input int which, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      case (which) 0: src_xtal = 1'b1; 1: src_ext = 1'b1; default: src_rc = 1'b1; endcase
      repeat (6) @(negedge clk);
      case (which) 0: src_xtal = 1'b0; 1: src_ext = 1'b0; default: src_rc = 1'b0; endcase
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 gpio", {31'b0, tmr_gpio}, 32'h0);
    chk("R1 irq", {31'b0, tmr_irq}, 32'h0);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    rd(5'h00, 32'h0, "R1 ctrl");
    rd(5'h04, 32'h0, "R1 step");
    rd(5'h08, 32'h0, "R1 thr");
    rd(5'h0C, 32'h0, "R1 cnt");
    rd(5'h10, 32'h0, "R1 status");

    // R2 readback
    wr(5'h04, 32'd3);
    wr(5'h08, 32'd10);
    wr(5'h00, 32'h3E);
    rd(5'h04, 32'd3, "R2 step");
    rd(5'h08, 32'd10, "R2 thr");
    rd(5'h00, 32'h3E, "R2 ctrl");

    // R5/R12: disabled preload holds
    wr(5'h00, 32'h00);
    wr(5'h0C, 32'd7);
    repeat (10) @(negedge clk);
    rd(5'h0C, 32'd7, "R12 R5 preload hold");

    // R7 one-shot from system clock: 0,3,6,9,12 -> halt at 12
    wr(5'h0C, 32'd0);
    wr(5'h00, 32'h03);
    repeat (12) @(negedge clk);
    chk("R6 R10 gpio toggled", {31'b0, tmr_gpio}, 32'h1);
    rd(5'h0C, 32'd12, "R7 halted value");
    rd(5'h10, 32'h1, "R6 sticky");
    repeat (5) @(negedge clk);
    rd(5'h0C, 32'd12, "R7 still halted");

    // R11 clear sticky
    wr(5'h10, 32'h1);
    rd(5'h10, 32'h0, "R11 w1c");

    // R7 re-arm by counter write
    wr(5'h0C, 32'd0);
    repeat (12) @(negedge clk);
    chk("R7 rearm toggle back", {31'b0, tmr_gpio}, 32'h0);
    rd(5'h0C, 32'd12, "R7 rearm value");

    // R3 back-pressure
    wr(5'h00, 32'h00);
    rsp_ready = 1'b0;
    rd(5'h04, 32'd3, "R3 held data");
    repeat (5) @(negedge clk);
    chk("R3 rsp held", {31'b0, rsp_valid}, 32'h1);
    chk("R3 ready low", {31'b0, bus_ready}, 32'h0);
    rsp_ready = 1'b1;

    // R9/R4 wrap with external source; other sources ignored
    wr(5'h04, 32'h6000_0000);
    wr(5'h08, 32'hF000_0000);
    wr(5'h0C, 32'h0);
    wr(5'h10, 32'h1);
    wr(5'h00, 32'h25);
    pulses(0, 3);
    pulses(2, 3);
    pulses(1, 4);
    repeat (4) @(negedge clk);
    wr(5'h00, 32'h24);
    rd(5'h0C, 32'h8000_0000, "R9 R4 wrap sum");
    rd(5'h10, 32'h1, "R6 carry event");
    chk("R6 gpio after carry", {31'b0, tmr_gpio}, 32'h1);
    chk("R10 irq low on gpio route", {31'b0, tmr_irq}, 32'h0);

    // R8/R4 restart with crystal source; 5,10,15->0,5
    wr(5'h04, 32'd5);
    wr(5'h08, 32'd12);
    wr(5'h0C, 32'h0);
    wr(5'h10, 32'h1);
    wr(5'h00, 32'h11);
    pulses(1, 2);
    pulses(0, 4);
    repeat (4) @(negedge clk);
    wr(5'h00, 32'h10);
    rd(5'h0C, 32'd5, "R8 R4 restart");
    chk("R6 gpio after restart event", {31'b0, tmr_gpio}, 32'h0);

    // R10 interrupt routing
    wr(5'h00, 32'h08);
    @(negedge clk);
    chk("R10 irq follows sticky", {31'b0, tmr_irq}, 32'h1);
    chk("R10 gpio low on irq route", {31'b0, tmr_gpio}, 32'h0);
    wr(5'h10, 32'h1);
    chk("R10 R11 irq cleared", {31'b0, tmr_irq}, 32'h0);

    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule